// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's fetch stage and a word-wide memory read port. It holds 256 lines of four 32-bit words (4 KB) and is indexed directly by the fetch address. The core offers one fetch at a time while `fetchReady` is high. The cache answers with a single-cycle `fetchValid` pulse carrying the instruction word. On a miss it reads the words it needs from memory, one read in flight at a time.

A miss brings in only the missed word and the words after it up to the end of the line. The tag of each line holds the full word-aligned fetch address that caused the fill. A lookup hits only when the line-address bits match and the fetch address is not below the stored tag. As a result, words in front of the starting point of a partial fill still miss. Invalidation writes all ones into every tag. Since word-aligned addresses never reach that value, no line can hit afterwards.

The address decoder reports through `pcMapped` whether a fetch falls in a mapped region. An unmapped fetch reports a bus error and returns a zero word, which executes as a no-op. A `bypass` input sends a fetch straight to memory and leaves the cache untouched.

Top module: `insn_line_cache`

## Requirements
- R1: Reset invalidates every line. After reset `fetchReady` is 1 and `fetchValid` and `memReq` are 0, and the first fetch to any address misses.
- R2: A hit returns the stored word selected by PC bits 3:2. It ignores PC bits 1:0, makes no memory read, and raises `fetchValid` in the cycle after the request is accepted.
- R3: A hit needs PC bits 31:4 equal to the stored tag bits 31:4 and the word-aligned PC greater than or equal to the stored tag. A lower word of a partly filled line therefore misses and refills the line from that word.
- R4: On a miss, the cache stores the word-aligned PC as the tag and reads words from the missed word offset up to word 3 of the line in ascending order. That is 4 minus the offset reads, each at address {PC[31:4], word, 2'b00}. It returns the missed word after the last read completes.
- R5: The line index is PC bits 11:4. A fetch whose index matches a line holding a different address replaces that line, and the old address then misses.
- R6: `invalidateAll` held for one cycle makes every later fetch miss, including PC 0xFFFFFFFC.
- R7: A fetch accepted with `pcMapped` low returns `fetchWord` 0 with `busError` high during the `fetchValid` cycle. It issues no memory read and leaves the cache contents unchanged.
- R8: A mapped fetch with `bypass` high issues exactly one read, of the word-aligned PC. It returns the memory word and neither allocates nor updates any line.
- R9: At most one memory read is outstanding: `memReq` is a one-cycle pulse and is not raised again until `memValid` has returned for it.
- R10: Each accepted fetch produces exactly one one-cycle `fetchValid` pulse. `fetchReady` stays low from acceptance through that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request, accepted when fetchReady is high |
| fetchPc | input | 32 | Fetch address |
| pcMapped | input | 1 | Address decoder: fetchPc lies in a mapped region |
| bypass | input | 1 | Serve this fetch from memory without touching the cache |
| invalidateAll | input | 1 | Mark every line as missing |
| fetchReady | output | 1 | Cache can accept a fetch this cycle |
| fetchValid | output | 1 | One-cycle pulse, fetchWord is valid |
| fetchWord | output | 32 | Returned instruction word |
| busError | output | 1 | Fetch was to an unmapped region (with fetchValid) |
| memReq | output | 1 | One-cycle memory word read request |
| memAddr | output | 32 | Word address of the read |
| memValid | input | 1 | Memory response strobe |
| memData | input | 32 | Memory response word |

## Verification
The checks assume that memory answers every read with exactly one `memValid` pulse, at least one cycle after `memReq`, and never volunteers a response. They also assume that `fetchPc`, `pcMapped` and `bypass` are meaningful in the cycle a request is accepted. The bench memory model watches for each read and replies after a programmable latency of one to three cycles. It changes its content between fetches, so that a stale cached word can be told apart from a fresh memory word. The driver raises `fetchReq` only while `fetchReady` is high, drops it after one cycle, and waits for the response before offering the next fetch.

// File: rtl/lcache_pkg.sv
package lcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FILL    = 2'd1,
    ST_RESPOND = 2'd2
  } fillState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;    // latch request address and starting word
    logic tagWrite;   // write the aligned PC into the indexed tag
    logic loadHit;    // response word from the cached line
    logic loadFault;  // response word forced to zero
    logic takeMem;    // memory word arrived for the current fill word
    logic fillWrite;  // store the memory word into the line
    logic stepWord;   // advance to the next word of the line
    logic wipe;       // set every tag to all ones
  } dpStrobes_t;

endpackage

// File: rtl/lcache_datapath.sv
module lcache_datapath
  import lcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        ctl,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [DATA_W-1:0] memData,
  output logic              hit,
  output logic              atLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] respWord
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int LO    = 2 + OFF_W;

  logic [ADDR_W-1:0] tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES][LINE_WORDS];

  logic [ADDR_W-1:0] pcAligned;
  logic [IDX_W-1:0]  reqIdx, curIdx;
  logic [OFF_W-1:0]  reqOff, curOff, fillWord;
  logic [ADDR_W-1:2] curPc;
  logic [ADDR_W-1:0] tagRd;

  assign pcAligned = fetchPc & ~ADDR_W'(3);
  assign reqIdx    = pcAligned[LO +: IDX_W];
  assign reqOff    = pcAligned[2 +: OFF_W];
  assign curIdx    = curPc[LO +: IDX_W];
  assign curOff    = curPc[2 +: OFF_W];
  assign tagRd     = tagMem[reqIdx];

  // line match plus the lower bound set by where the fill began
  assign hit    = (pcAligned[ADDR_W-1:LO] == tagRd[ADDR_W-1:LO]) && (pcAligned >= tagRd);
  assign atLast = (fillWord == OFF_W'(LINE_WORDS - 1));
  assign memAddr = {curPc[ADDR_W-1:LO], fillWord, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) tagMem[i] <= '1;
      curPc    <= '0;
      fillWord <= '0;
      respWord <= '0;
    end else begin
      if (ctl.capture) begin
        curPc    <= pcAligned[ADDR_W-1:2];
        fillWord <= reqOff;
      end
      if (ctl.tagWrite)  tagMem[reqIdx] <= pcAligned;
      if (ctl.loadHit)   respWord <= dataMem[reqIdx][reqOff];
      if (ctl.loadFault) respWord <= '0;
      if (ctl.takeMem && (fillWord == curOff)) respWord <= memData;
      if (ctl.stepWord)  fillWord <= fillWord + 1'b1;
      if (ctl.wipe) begin
        for (int i = 0; i < LINES; i++) tagMem[i] <= '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillWrite) dataMem[curIdx][fillWord] <= memData;
  end

endmodule

// File: rtl/lcache_control.sv
module lcache_control
  import lcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchReq,
  input  logic       pcMapped,
  input  logic       bypass,
  input  logic       invalidateAll,
  input  logic       hit,
  input  logic       atLast,
  input  logic       memValid,
  output dpStrobes_t ctl,
  output logic       memReq,
  output logic       fetchReady,
  output logic       fetchValid,
  output logic       busError
);
  fillState_t state, stateNext;
  logic waitResp, isBypass, faultFlag;

  always_comb begin
    ctl       = '0;
    ctl.wipe  = invalidateAll;
    stateNext = state;
    memReq    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (fetchReq) begin
          ctl.capture = 1'b1;
          if (!pcMapped) begin
            ctl.loadFault = 1'b1;
            stateNext     = ST_RESPOND;
          end else if (bypass) begin
            stateNext = ST_FILL;
          end else if (hit) begin
            ctl.loadHit = 1'b1;
            stateNext   = ST_RESPOND;
          end else begin
            ctl.tagWrite = 1'b1;
            stateNext    = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq = !waitResp;
        if (waitResp && memValid) begin
          ctl.takeMem   = 1'b1;
          ctl.fillWrite = !isBypass;
          if (isBypass || atLast) stateNext = ST_RESPOND;
          else ctl.stepWord = 1'b1;
        end
      end
      ST_RESPOND: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitResp  <= 1'b0;
      isBypass  <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (memReq) waitResp <= 1'b1;
      else if (memValid) waitResp <= 1'b0;
      if (ctl.capture) begin
        isBypass  <= pcMapped && bypass;
        faultFlag <= !pcMapped;
      end
    end
  end

  assign fetchReady = (state == ST_IDLE);
  assign fetchValid = (state == ST_RESPOND);
  assign busError   = fetchValid && faultFlag;

endmodule

// File: rtl/insn_line_cache.sv
module insn_line_cache
  import lcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              pcMapped,
  input  logic              bypass,
  input  logic              invalidateAll,
  output logic              fetchReady,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchWord,
  output logic              busError,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData
);
  dpStrobes_t ctl;
  logic hit, atLast;

  lcache_control u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .pcMapped(pcMapped),
    .bypass(bypass), .invalidateAll(invalidateAll), .hit(hit), .atLast(atLast),
    .memValid(memValid), .ctl(ctl), .memReq(memReq), .fetchReady(fetchReady),
    .fetchValid(fetchValid), .busError(busError)
  );

  lcache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fetchPc(fetchPc), .memData(memData),
    .hit(hit), .atLast(atLast), .memAddr(memAddr), .respWord(fetchWord)
  );

endmodule

// File: rtl/insn_line_cache_chk.sv
module insn_line_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic              pcMapped,
  input logic              fetchReady,
  input logic              fetchValid,
  input logic [DATA_W-1:0] fetchWord,
  input logic              busError,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= 1'b0;
    else if (memReq) pend <= 1'b1;
    else if (memValid) pend <= 1'b0;
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> !fetchValid); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !fetchReady); // R10
  AST_UNMAPPED_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchReady && !pcMapped) |=> (fetchValid && busError && fetchWord == '0)); // R7
  AST_UNMAPPED_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchReady && !pcMapped) |=> !memReq); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !pend); // R9
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R9
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R4

endmodule

bind insn_line_cache insn_line_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .pcMapped(pcMapped),
  .fetchReady(fetchReady), .fetchValid(fetchValid), .fetchWord(fetchWord),
  .busError(busError), .memReq(memReq), .memAddr(memAddr), .memValid(memValid)
);

// File: tb/tb_insn_line_cache.sv
module tb_insn_line_cache;
  localparam int LINES = 256;
  localparam int LINE_WORDS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, fetchReq = 1'b0, pcMapped = 1'b1, bypass = 1'b0, invalidateAll = 1'b0;
  logic [31:0] fetchPc = '0;
  logic fetchReady, fetchValid, busError, memReq;
  logic [31:0] fetchWord, memAddr;
  logic memValid = 1'b0;
  logic [31:0] memData = '0;

  insn_line_cache dut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchPc(fetchPc),
    .pcMapped(pcMapped), .bypass(bypass), .invalidateAll(invalidateAll),
    .fetchReady(fetchReady), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .busError(busError), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData)
  );

  int checks = 0, fails = 0;
  int memReads = 0, overlaps = 0, memLat = 1;
  logic [31:0] memSalt = 32'h5A5A_F00F;
  logic [31:0] mTag  [LINES];
  logic [31:0] mData [LINES][LINE_WORDS];
  bit done = 1'b0;

  typedef struct {
    logic [31:0] word;
    logic        err;
    int          reads;
    int          startReads;
    string       req;
  } expItem_t;
  expItem_t sb[$];

  function automatic logic [31:0] memWordAt(input logic [31:0] a);
    return a ^ memSalt;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: one read at a time, programmable latency
  initial begin
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      if (memReq) begin
        logic [31:0] a;
        a = memAddr;
        memReads++;
        for (int k = 0; k < memLat; k++) begin
          @(negedge clk);
          if (memReq) overlaps++;
        end
        memValid = 1'b1;
        memData  = memWordAt(a);
      end
    end
  end

  // monitor: pop expected items as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (fetchValid) begin
        if (sb.size() == 0) begin
          check("R10", "unexpected fetchValid", 32'd1, 32'd0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          check(it.req, "fetchWord", fetchWord, it.word);
          check(it.req, "busError", {31'd0, busError}, {31'd0, it.err});
          check(it.req, "memory reads", 32'(memReads - it.startReads), 32'(it.reads));
          check("R10", "fetchReady during response", {31'd0, fetchReady}, 32'd0);
        end
      end
    end
  end

  task automatic doFetch(input logic [31:0] pc, input logic mapped, input logic byp, input string req);
    expItem_t it;
    logic [31:0] pa;
    logic [7:0] idx;
    logic [1:0] off;
    pa  = {pc[31:2], 2'b00};
    idx = pa[11:4];
    off = pa[3:2];
    it.req = req;
    it.err = 1'b0;
    if (!mapped) begin
      it.word = '0; it.err = 1'b1; it.reads = 0;
    end else if (byp) begin
      it.word = memWordAt(pa); it.reads = 1;
    end else if (pa[31:4] == mTag[idx][31:4] && pa >= mTag[idx]) begin
      it.word = mData[idx][off]; it.reads = 0;
    end else begin
      mTag[idx] = pa;
      for (int w = int'(off); w < LINE_WORDS; w++)
        mData[idx][w] = memWordAt({pa[31:4], w[1:0], 2'b00});
      it.word  = mData[idx][off];
      it.reads = LINE_WORDS - int'(off);
    end
    while (!fetchReady) @(negedge clk);
    it.startReads = memReads;
    sb.push_back(it);
    fetchReq = 1'b1; fetchPc = pc; pcMapped = mapped; bypass = byp;
    @(negedge clk);
    fetchReq = 1'b0; pcMapped = 1'b1; bypass = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doInvalidate();
    invalidateAll = 1'b1;
    @(negedge clk);
    invalidateAll = 1'b0;
    for (int i = 0; i < LINES; i++) mTag[i] = '1;
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) mTag[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check("R1", "fetchReady", {31'd0, fetchReady}, 32'd1);
    check("R1", "fetchValid", {31'd0, fetchValid}, 32'd0);
    check("R1", "memReq", {31'd0, memReq}, 32'd0);
    doFetch(32'h0000_0100, 1'b1, 1'b0, "R1");    // first fetch misses, full line
    doFetch(32'h0000_0104, 1'b1, 1'b0, "R2");
    doFetch(32'h0000_010C, 1'b1, 1'b0, "R2");
    doFetch(32'h0000_0107, 1'b1, 1'b0, "R2");    // low bits ignored
    doFetch(32'h0000_0208, 1'b1, 1'b0, "R4");    // partial fill, two reads
    doFetch(32'h0000_020C, 1'b1, 1'b0, "R2");
    doFetch(32'h0000_0200, 1'b1, 1'b0, "R3");    // below tag: miss
    doFetch(32'h0000_0204, 1'b1, 1'b0, "R3");    // now hits
    doFetch(32'h0000_1100, 1'b1, 1'b0, "R5");    // same index, replaces
    doFetch(32'h0000_0100, 1'b1, 1'b0, "R5");    // old address misses again
    memLat = 3;
    doFetch(32'h0000_1104, 1'b1, 1'b0, "R4");    // three reads, slow memory
    memSalt = 32'hC3C3_1234;                     // memory content changes
    doFetch(32'h0000_1108, 1'b1, 1'b0, "R2");    // stale hit
    doFetch(32'h0000_1108, 1'b1, 1'b1, "R8");    // bypass sees new data
    doFetch(32'h0000_1108, 1'b1, 1'b0, "R8");    // line unchanged by bypass
    doFetch(32'h0000_1108, 1'b0, 1'b0, "R7");    // unmapped
    doFetch(32'h0000_0400, 1'b0, 1'b0, "R7");
    doFetch(32'h0000_1108, 1'b1, 1'b0, "R7");    // cache unchanged by fault
    memLat = 2;
    doInvalidate();
    doFetch(32'h0000_1108, 1'b1, 1'b0, "R6");    // miss after invalidate
    doFetch(32'hFFFF_FFFC, 1'b1, 1'b0, "R6");    // top word still misses
    doFetch(32'hFFFF_FFFE, 1'b1, 1'b0, "R2");
    memLat = 1;
    doFetch(32'h0000_0300, 1'b1, 1'b1, "R8");    // bypass does not allocate
    doFetch(32'h0000_0300, 1'b1, 1'b0, "R8");
    check("R9", "overlapping reads", 32'(overlaps), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule